// File: doc/BRIEF.md
# I2C Byte-Memory Target

This block is the target side of a two-wire serial bus, placed in front of a small byte-wide memory array. A system clock oversamples the clock and data lines. Each line passes through a synchronizer before the block looks for edges and bus conditions. A transaction opens with a START and selects this device with a select byte. A select byte matches when its fixed four-bit prefix is followed by the three bits on the strap inputs. After a write-direction select, the host sends a two-byte word address and then any number of data bytes. The block stores the data bytes in sequence. After a read-direction select, the block sends bytes from the current address for as long as the host acknowledges them.

The data line is never driven high. The block has only a pull-low enable, and the host side of the wire is resolved outside the block. Neither bus line has a valid/ready handshake: the host's clock paces every transfer, and the target cannot apply back-pressure because it never holds the clock low. The write-protect input gates stores into the array without changing the acknowledge pattern. The memory depth is set by a parameter, and only the low address bits that index the array are kept.

Top module: `i2c_memslave`

## Requirements
- R1: The block ignores all bus activity until a START, which is the data line falling while the clock line is high. A STOP, which is the data line rising while the clock line is high, returns the block to idle.
- R2: The first byte after a START is the select byte, sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal the strap inputs (bit 3 matches strap bit 2). Bit 0 gives the direction: 1 is read, 0 is write. On a match the block pulls the data line low for the whole ninth clock.
- R3: On a non-matching select byte the block gives no acknowledge. It stays released and ignores every later byte until the next START.
- R4: After a write select, the next two bytes are the word address, high byte first. Each is acknowledged. Only the low MEM_AW bits of the 16-bit value load the address pointer; the upper bits have no effect.
- R5: Each data byte after the address is acknowledged and stored at the pointer. The pointer then advances by one and wraps from the last location to zero.
- R6: After a read select, the block sends the byte at the pointer MSB first. A 0 bit pulls the line low and a 1 bit releases it. The block releases the line during the ninth clock and advances the pointer. It sends the next byte if the host drove that ninth bit low, and goes idle if the host left it high.
- R7: A repeated START restarts select decoding but keeps the pointer. A write select plus address followed by a read select therefore reads from the new address. A read select with no address reads on from the last pointer value.
- R8: While write-protect is high, data bytes are still acknowledged but the array is not changed.
- R9: The drive-low enable changes only while the synchronized clock line is low.
- R10: The synchronous reset releases the data line and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low | output | 1 | When 1, the data line is pulled low |
| dev_strap | input | 3 | Device select strap bits |
| wr_protect | input | 1 | When 1, stores into the array are suppressed |

## Verification
Assertions check on every cycle that the line drive changes only while the clock is low, that it stays released in idle and during the host's acknowledge slot, that a select acknowledge follows only a matching select byte, that each store advances the pointer by one, and that the bit counter stays in range. Only the bench scenarios can show that the stored and returned byte values are correct. The same holds for wrap-around across the whole array, for the address bits that are ignored, for bytes that write protect suppresses, and for the pointer carried across a repeated START. These are shown by filling and reading back every location of the default array and comparing against arithmetic patterns.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } xfer_state_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout,
  output logic [LINES-1:0] dprev
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain  <= '1;
        last_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], din[i]};
        last_q <= chain[STAGES-1];
      end
    end
    assign dout[i]  = chain[STAGES-1];
    assign dprev[i] = last_q;
  end
endmodule

// File: rtl/i2cm_busdet.sv
module i2cm_busdet (
  input  logic scl_now,
  input  logic scl_old,
  input  logic sda_now,
  input  logic sda_old,
  output logic cond_start,
  output logic cond_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_held_high;
  always_comb begin
    scl_held_high = scl_now & scl_old;
    cond_start    = scl_held_high & sda_old & ~sda_now;
    cond_stop     = scl_held_high & ~sda_old & sda_now;
    scl_rise      = ~scl_old & scl_now;
    scl_fall      = scl_old & ~scl_now;
  end
endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end
  assign rdata = cells[addr];
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cond_start,
  input  logic              cond_stop,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [2:0]        strap,
  input  logic              wp,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              sda_drv
);
  localparam logic [3:0]        FULL_CNT = 4'(BYTE_BITS);
  localparam logic [MEM_AW-1:0] PTR_ONE  = MEM_AW'(1);

  xfer_state_t       state;
  logic [3:0]        cnt;
  logic              ack_ph;
  logic [7:0]        shreg;
  logic [7:0]        ahi;
  logic              rw;
  logic              mack;
  logic [MEM_AW-1:0] ptr;

  logic        byte_done, ack_end, dev_match;
  logic [15:0] word;

  always_comb begin
    byte_done = scl_fall && !ack_ph && (cnt == FULL_CNT);
    ack_end   = scl_fall && ack_ph;
    dev_match = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap);
    word      = {ahi, shreg};
    mem_we    = (state == ST_WR) && byte_done && !wp;
    mem_addr  = ptr;
    mem_wdata = shreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      shreg   <= '0;
      ahi     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b1;
      ptr     <= '0;
      sda_drv <= 1'b0;
    end else if (cond_start) begin
      state   <= ST_DEV;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      sda_drv <= 1'b0;
    end else if (cond_stop) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ack_ph  <= 1'b0;
      sda_drv <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_RD: begin
          if (scl_rise) begin
            if (cnt != FULL_CNT) cnt <= cnt + 4'd1;
            else                 mack <= sda_s;
          end else if (byte_done) begin
            sda_drv <= 1'b0;
            ack_ph  <= 1'b1;
            ptr     <= ptr + PTR_ONE;
          end else if (ack_end) begin
            ack_ph <= 1'b0;
            if (!mack) begin
              shreg   <= rd_data;
              sda_drv <= !rd_data[7];
              cnt     <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else if (scl_fall) begin
            shreg   <= {shreg[6:0], 1'b0};
            sda_drv <= !shreg[6];
          end
        end
        default: begin
          if (scl_rise && cnt != FULL_CNT) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_done) begin
            if (state == ST_DEV && !dev_match) begin
              state <= ST_IDLE;
            end else begin
              sda_drv <= 1'b1;
              ack_ph  <= 1'b1;
              case (state)
                ST_DEV:  rw  <= shreg[0];
                ST_AHI:  ahi <= shreg;
                ST_ALO:  ptr <= word[MEM_AW-1:0];
                ST_WR:   ptr <= ptr + PTR_ONE;
                default: ;
              endcase
            end
          end else if (ack_end) begin
            sda_drv <= 1'b0;
            ack_ph  <= 1'b0;
            cnt     <= '0;
            case (state)
              ST_DEV: begin
                if (rw) begin
                  state   <= ST_RD;
                  shreg   <= rd_data;
                  sda_drv <= !rd_data[7];
                end else begin
                  state <= ST_AHI;
                end
              end
              ST_AHI:  state <= ST_ALO;
              ST_ALO:  state <= ST_WR;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  // R9: the line drive moves only while the clock line is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drv) |-> !scl_s);

  // R3 / R1: idle means released
  a_r3_idle_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_drv);

  // R6: host acknowledge slot is never driven by the target
  a_r6_host_slot_free: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && ack_ph) |-> !sda_drv);

  // R2: a select acknowledge needs a matching select byte
  a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_drv) && state == ST_DEV) |-> dev_match);

  // R5: every store is followed by a one-step pointer advance
  a_r5_ptr_advance: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (ptr == MEM_AW'($past(ptr) + PTR_ONE)));

  // R1: bit counter stays inside a byte frame
  a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);
endmodule

// File: rtl/i2c_memslave.sv
module i2c_memslave #(
  parameter int MEM_AW      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_drive_low,
  input  logic [2:0] dev_strap,
  input  logic       wr_protect
);
  logic [1:0] line_s, line_p;
  logic       st_c, sp_c, rise_c, fall_c;
  logic              we;
  logic [MEM_AW-1:0] addr;
  logic [7:0]        wdata, rdata;

  i2cm_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   ({scl_i, sda_i}),
    .dout  (line_s),
    .dprev (line_p)
  );

  i2cm_busdet u_det (
    .scl_now    (line_s[1]),
    .scl_old    (line_p[1]),
    .sda_now    (line_s[0]),
    .sda_old    (line_p[0]),
    .cond_start (st_c),
    .cond_stop  (sp_c),
    .scl_rise   (rise_c),
    .scl_fall   (fall_c)
  );

  i2cm_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cond_start (st_c),
    .cond_stop  (sp_c),
    .scl_rise   (rise_c),
    .scl_fall   (fall_c),
    .scl_s      (line_s[1]),
    .sda_s      (line_s[0]),
    .strap      (dev_strap),
    .wp         (wr_protect),
    .rd_data    (rdata),
    .mem_we     (we),
    .mem_addr   (addr),
    .mem_wdata  (wdata),
    .sda_drv    (sda_drive_low)
  );

  i2cm_mem #(.AW(MEM_AW), .DW(8)) u_mem (
    .clk   (clk),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: tb/i2c_memslave_bench.sv
module i2c_memslave_bench;
  localparam int Q     = 4;
  localparam int DEPTH = 256;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic dut_low;
  logic sda_line;
  logic drv_seen = 1'b0;
  int   checks = 0;
  int   fails  = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | dut_low);

  always @(negedge clk) if (dut_low) drv_seen <= 1'b1;

  i2c_memslave u_i2c_memslave (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (m_scl),
    .sda_i         (sda_line),
    .sda_drive_low (dut_low),
    .dev_strap     (STRAP),
    .wr_protect    (wp)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b1; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_restart();
    m_low = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_low = 1'b1; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_low = 1'b0; w(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; w(Q); m_scl = 1'b1; w(Q); b = sda_line; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic header(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a0, a1, a2;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a0);
    send_byte(hi, a1);
    send_byte(lo, a2);
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
  endtask

  task automatic read_run(input int n, input int first, input string req);
    logic a;
    logic [7:0] v;
    send_byte({4'b1010, STRAP, 1'b1}, a);
    chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(v == model[(first + i) % DEPTH], req, v, model[(first + i) % DEPTH]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    w(5);
    chk(dut_low == 1'b0, "R10 reset released", dut_low, 0);
    rst = 1'b0;
    w(5);

    // R1: bytes clocked without START are ignored
    m_scl = 1'b0; w(Q);
    send_byte({4'b1010, STRAP, 1'b0}, a);
    chk(!a && !drv_seen, "R1 no START ignored", drv_seen, 0);
    bus_stop();

    // R2 / R3: sweep every strap value of the select byte
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte({4'b1010, 3'(s), 1'b0}, a);
      chk(a == (s == int'(STRAP)), "R2 strap sweep", a, s == int'(STRAP));
      if (!a) begin
        send_byte({4'b1010, STRAP, 1'b0}, a);
        chk(!a, "R3 ignored until START", a, 0);
      end
      bus_stop();
    end

    // R2: sweep every wrong prefix
    for (int p = 0; p < 16; p++) begin
      if (p != 10) begin
        bus_start();
        send_byte({4'(p), STRAP, 1'b0}, a);
        chk(!a, "R2 prefix sweep", a, 0);
        bus_stop();
      end
    end

    // R5: fill the whole array and wrap two bytes past the top
    header(8'h00, 8'h00, "R4 address acked");
    begin
      logic all_ack;
      all_ack = 1'b1;
      for (int i = 0; i < DEPTH + 2; i++) begin
        v = (i < DEPTH) ? pat(i) : ~pat(i - DEPTH);
        send_byte(v, a);
        all_ack &= a;
        model[i % DEPTH] = v;
      end
      chk(all_ack, "R5 data acked", all_ack, 1);
    end
    bus_stop();

    // R6 / R7: random read of all locations, running over the wrap
    header(8'h00, 8'h00, "R7 header");
    bus_restart();
    read_run(DEPTH + 2, 0, "R6 sequential read");

    // R4: upper word-address bits ignored
    header(8'h3F, 8'h05, "R4 high header");
    send_byte(8'h5A, a);
    chk(a, "R4 data acked", a, 1);
    model[5] = 8'h5A;
    bus_stop();
    header(8'h12, 8'h05, "R4 alias header");
    bus_restart();
    read_run(1, 5, "R4 alias read");

    // R8: write protect acks but keeps contents
    wp = 1'b1;
    header(8'h00, 8'h10, "R8 header");
    send_byte(~model[16], a);
    chk(a, "R8 protected byte acked", a, 1);
    send_byte(~model[17], a);
    chk(a, "R8 protected byte acked", a, 1);
    bus_stop();
    wp = 1'b0;
    header(8'h00, 8'h10, "R8 readback header");
    bus_restart();
    read_run(2, 16, "R8 contents kept");

    // R7 / R5: read across the top, then current-address read
    header(8'h00, 8'hFE, "R7 wrap header");
    bus_restart();
    read_run(4, 254, "R5 read wrap");
    bus_start();
    read_run(1, 2, "R7 current address read");

    // R10: reset in the middle of a select acknowledge
    bus_start();
    for (int i = 7; i >= 0; i--) put_bit(v[i] | 1'b1 ? ({4'b1010, STRAP, 1'b0} >> i) & 1'b1 : 1'b0);
    m_low = 1'b0; w(Q); m_scl = 1'b1; w(Q);
    chk(dut_low == 1'b1, "R2 ack during ninth clock", dut_low, 1);
    rst = 1'b1; w(2); rst = 1'b0; w(1);
    chk(dut_low == 1'b0, "R10 reset mid transfer", dut_low, 0);
    w(Q); m_scl = 1'b0; w(Q);
    bus_stop();
    bus_start();
    read_run(1, 0, "R10 operates after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule